// File: doc/BRIEF.md
# E1 Frame Alignment Receiver

This block recovers the frame boundary of a serial 2.048 Mbit/s E1 stream. Bits arrive one per clock on which `bit_en` is high. A frame holds 32 time slots of 8 bits each, so one frame is 256 bits. Time slot 0 alternates between two kinds of frame. The FAS frame carries the 7-bit alignment word `0011011`. The non-FAS frame carries a fixed 1 and the alarm bits. Bits inside a slot are numbered 1 to 8 in the order they arrive.

While unlocked, the receiver slides across the stream looking for the alignment word. After a candidate hit it makes two checks. Bit 2 of time slot 0 in the next frame must be 1. The alignment word must appear again exactly 512 bits after the hit. Only then is lock declared.

In lock, the receiver checks the alignment word in every FAS frame. It declares loss of frame after a run of errored words. It also reports where the most recently accepted bit sits in the two-frame cycle, and it latches the remote alarm bit taken from non-FAS frames.

Top module: `e1_frame_aligner`

## Requirements
- R1: After a synchronous active-low reset the outputs are as follows: `locked`=0, `lof_alarm`=0, `remote_alarm`=0, `slot_num`=0, `bit_pos`=0 and `fas_frame`=1.
- R2: In a cycle where `bit_en` is low, `bit_in` is ignored and no output changes on the following clock.
- R3: Each accepted bit moves the reported position forward by one, with one exception. While hunting, if this bit and the six bits before it equal `0011011` (earliest bit first), the position is set to slot 0 bit 8 of a FAS frame. The position has three fields. `bit_pos` 0..7 stands for bits 1..8 of the slot. `slot_num` is 0..31. `fas_frame` is 1 in FAS frames and 0 in non-FAS frames, and it toggles each time the position wraps from slot 31 bit 8. Outputs update on the clock edge that accepts the bit.
- R4: After a candidate hit, the bit accepted 250 bits later (bit 2 of time slot 0 in the non-FAS frame) must be 1. A 0 sends the receiver back to hunting.
- R5: The alignment word must also be present on the bit 512 bits after the candidate hit. If it is, `locked` rises on the edge that accepts that bit, with the position reading slot 0 bit 8 of a FAS frame. If it is not, the receiver hunts again.
- R6: Bit 1 of time slot 0 plays no part in alignment matching.
- R7: In lock, `ERR_LIMIT` (default 3) consecutive FAS frames with an errored alignment word clear `locked` and set `lof_alarm` on the edge that accepts bit 8 of the last errored word. A correct word resets the run.
- R8: `lof_alarm` stays set until lock is next declared and then clears, and it is never high while `locked` is high.
- R9: While locked, bit 3 of time slot 0 in each non-FAS frame is copied to `remote_alarm` when that bit is accepted. At any other bit position `remote_alarm` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` for this clock |
| bit_in | input | 1 | Serial line data |
| locked | output | 1 | Frame alignment held |
| slot_num | output | 5 | Time slot of the last accepted bit |
| bit_pos | output | 3 | Bit within the slot, 0 = bit 1 |
| fas_frame | output | 1 | 1 when the last bit lies in a FAS frame |
| lof_alarm | output | 1 | Loss of frame declared |
| remote_alarm | output | 1 | Latched remote alarm bit |

## Verification
The stream is built from frames with all-ones payload, so the alignment word can only occur where the frame puts it. Table entries shift the first frame by different leading offsets to show that the hunt is independent of the starting phase. Other entries spoil either the non-FAS bit 2 or the second alignment word, which separates a failure at the first check from a failure at the second. Directed runs then exercise the following:
- an error run broken by a good word against an unbroken run of three;
- relock and the clearing of the alarm;
- a remote alarm bit sampled just before and just after its bit position;
- a cleared bit 1;
- an idle stretch with the enable low.

// File: rtl/e1fa_pkg.sv
// Package: constants and types shared by the E1 frame alignment receiver.
// Assumes the 2-frame position counter covers 512 bits: frame parity, slot, bit.
package e1fa_pkg;
    localparam int SLOT_BITS  = 8;
    localparam int NUM_SLOTS  = 32;
    localparam int FRAME_BITS = SLOT_BITS * NUM_SLOTS;
    localparam int PAIR_BITS  = 2 * FRAME_BITS;
    localparam int BIT_W      = $clog2(SLOT_BITS);
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int POS_W      = $clog2(PAIR_BITS);
    localparam int WORD_W     = 7;

    localparam logic [WORD_W-1:0] ALIGN_WORD = 7'b0011011;

    // Positions within the two-frame cycle (FAS frame first).
    localparam logic [POS_W-1:0] POS_WORD_END = POS_W'(SLOT_BITS - 1);
    localparam logic [POS_W-1:0] POS_NF_BIT2  = POS_W'(FRAME_BITS + 1);
    localparam logic [POS_W-1:0] POS_NF_BIT3  = POS_W'(FRAME_BITS + 2);

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_NFAS = 2'd1,
        ST_FAS  = 2'd2,
        ST_LOCK = 2'd3
    } align_state_t;
endpackage

// File: rtl/e1fa_window.sv
// Module: sliding match window for the alignment word.
// Keeps the last WORD_W-1 accepted bits; word_hit is combinational and
// includes the bit being presented now. Earliest bit is compared with the MSB.
module e1fa_window
    import e1fa_pkg::*;
#(
    parameter logic [WORD_W-1:0] PATTERN = ALIGN_WORD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic word_hit
);
    localparam int HIST_W = WORD_W - 1;

    logic [HIST_W-1:0] hist_q;

    // Shift each accepted bit into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else if (bit_en) begin
            hist_q <= {hist_q[HIST_W-2:0], bit_in};
        end
    end

    // Compare history plus current bit with the pattern.
    always_comb begin
        word_hit = ({hist_q, bit_in} == PATTERN);
    end
endmodule

// File: rtl/e1fa_position.sv
// Module: two-frame bit position counter.
// Counts accepted bits modulo 512; realign forces the position of the
// accepted bit to slot 0 bit 8 of a FAS frame. inc_pos is the position the
// incoming bit takes when no realignment occurs.
module e1fa_position
    import e1fa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             realign,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] inc_pos
);
    logic [POS_W-1:0] pos_q;

    // Next position by plain increment (wraps at the two-frame length).
    always_comb begin
        inc_pos = pos_q + POS_W'(1);
    end

    // Advance or realign on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (bit_en) begin
            pos_q <= realign ? POS_WORD_END : inc_pos;
        end
    end

    assign pos = pos_q;
endmodule

// File: rtl/e1fa_sync_fsm.sv
// Module: hunt / verify / lock state machine with loss-of-frame and
// remote-alarm capture. Assumes inc_pos is the position of the bit on bit_in
// (valid outside the hunt) and word_hit covers that bit.
module e1fa_sync_fsm
    import e1fa_pkg::*;
#(
    parameter int ERR_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             word_hit,
    input  logic [POS_W-1:0] inc_pos,
    output logic             realign,
    output logic             locked,
    output logic             lof_alarm,
    output logic             remote_alarm
);
    localparam int ERR_W = (ERR_LIMIT > 1) ? $clog2(ERR_LIMIT + 1) : 1;
    localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(ERR_LIMIT - 1);

    align_state_t     state_q, state_d;
    logic [ERR_W-1:0] err_q, err_d;
    logic             lof_q, lof_d;
    logic             ra_q, ra_d;
    logic             at_word, at_nf_b2, at_nf_b3;

    // Decode the bit slots this machine acts on.
    always_comb begin
        at_word  = (inc_pos == POS_WORD_END);
        at_nf_b2 = (inc_pos == POS_NF_BIT2);
        at_nf_b3 = (inc_pos == POS_NF_BIT3);
    end

    // Next-state, error run, alarm and realign decisions.
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        lof_d   = lof_q;
        ra_d    = ra_q;
        realign = 1'b0;
        if (bit_en) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (word_hit) begin
                        state_d = ST_NFAS;
                        realign = 1'b1;
                    end
                end
                ST_NFAS: begin
                    if (at_nf_b2) begin
                        state_d = bit_in ? ST_FAS : ST_HUNT;
                    end
                end
                ST_FAS: begin
                    if (at_word) begin
                        if (word_hit) begin
                            state_d = ST_LOCK;
                            lof_d   = 1'b0;
                            err_d   = '0;
                        end else begin
                            state_d = ST_HUNT;
                        end
                    end
                end
                ST_LOCK: begin
                    if (at_nf_b3) begin
                        ra_d = bit_in;
                    end
                    if (at_word) begin
                        if (word_hit) begin
                            err_d = '0;
                        end else if (err_q >= ERR_LAST) begin
                            state_d = ST_HUNT;
                            err_d   = '0;
                            lof_d   = 1'b1;
                        end else begin
                            err_d = err_q + ERR_W'(1);
                        end
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // Register state, error run and alarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            err_q   <= '0;
            lof_q   <= 1'b0;
            ra_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            lof_q   <= lof_d;
            ra_q    <= ra_d;
        end
    end

    assign locked       = (state_q == ST_LOCK);
    assign lof_alarm    = lof_q;
    assign remote_alarm = ra_q;
endmodule

// File: rtl/e1_frame_aligner.sv
// Module: E1 frame alignment receiver (top).
// Takes one line bit per bit_en, finds and holds the 256-bit frame boundary
// from the alignment word in time slot 0, and reports the position of the
// last accepted bit. Assumes line decoding happened upstream.
module e1_frame_aligner
    import e1fa_pkg::*;
#(
    parameter int ERR_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              locked,
    output logic [SLOT_W-1:0] slot_num,
    output logic [BIT_W-1:0]  bit_pos,
    output logic              fas_frame,
    output logic              lof_alarm,
    output logic              remote_alarm
);
    logic             word_hit;
    logic             realign;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] inc_pos;

    e1fa_window #(.PATTERN(ALIGN_WORD)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .word_hit (word_hit)
    );

    e1fa_position u_position (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .realign (realign),
        .pos     (pos),
        .inc_pos (inc_pos)
    );

    e1fa_sync_fsm #(.ERR_LIMIT(ERR_LIMIT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .bit_in       (bit_in),
        .word_hit     (word_hit),
        .inc_pos      (inc_pos),
        .realign      (realign),
        .locked       (locked),
        .lof_alarm    (lof_alarm),
        .remote_alarm (remote_alarm)
    );

    // Split the two-frame position into its reported fields.
    always_comb begin
        bit_pos   = pos[BIT_W-1:0];
        slot_num  = pos[BIT_W +: SLOT_W];
        fas_frame = ~pos[POS_W-1];
    end
endmodule

// File: rtl/e1fa_checker.sv
// Module: property checker for e1_frame_aligner, attached by bind.
// Observes ports only.
module e1fa_checker
    import e1fa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              locked,
    input logic [SLOT_W-1:0] slot_num,
    input logic [BIT_W-1:0]  bit_pos,
    input logic              fas_frame,
    input logic              lof_alarm,
    input logic              remote_alarm
);
    logic [POS_W-1:0] pos_seen;

    // Rebuild the two-frame position from the output fields.
    always_comb begin
        pos_seen = {~fas_frame, slot_num, bit_pos};
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable({locked, lof_alarm, remote_alarm, slot_num, bit_pos, fas_frame}));

    p_step_in_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bit_en) |=> (!locked || pos_seen == $past(pos_seen) + POS_W'(1)));

    p_lock_at_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (slot_num == '0 && bit_pos == BIT_W'(7) && fas_frame));

    p_loss_at_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof_alarm) |-> ($past(locked) && slot_num == '0 && bit_pos == BIT_W'(7) && fas_frame));

    p_alarm_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lof_alarm |-> !locked);

    p_ra_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_alarm != $past(remote_alarm)) |->
            ($past(bit_en) && locked && slot_num == '0 && bit_pos == BIT_W'(2) && !fas_frame));
endmodule

bind e1_frame_aligner e1fa_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .locked       (locked),
    .slot_num     (slot_num),
    .bit_pos      (bit_pos),
    .fas_frame    (fas_frame),
    .lof_alarm    (lof_alarm),
    .remote_alarm (remote_alarm)
);

// File: tb/e1_frame_aligner_tb.sv
`timescale 1ns/1ps
// Bench: scenario table walked by one loop, then directed tests.
module e1_frame_aligner_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       locked, fas_frame, lof_alarm, remote_alarm;
    logic [4:0] slot_num;
    logic [2:0] bit_pos;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    e1_frame_aligner dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .bit_in       (bit_in),
        .locked       (locked),
        .slot_num     (slot_num),
        .bit_pos      (bit_pos),
        .fas_frame    (fas_frame),
        .lof_alarm    (lof_alarm),
        .remote_alarm (remote_alarm)
    );

    // Fields: [13:6] leading ones, [5] ra, [4] bad non-FAS bit 2,
    // [3] bad second word, [2] locked after frame 2, [1] after frame 4, [0] ra out.
    localparam logic [13:0] SCEN [6] = '{
        {8'd0,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {8'd37,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'd200, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd5,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd130, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {8'd1,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_pos(input string req, input int slot, input int bp, input int fas);
        check(req, "slot_num", int'(slot_num), slot);
        check(req, "bit_pos", int'(bit_pos), bp);
        check(req, "fas_frame", int'(fas_frame), fas);
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present one bit for one clock, then return after the edge that took it.
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    // Line bit at index idx of a frame; payload is all ones.
    function automatic logic frame_bit(input logic fas, input logic ra, input logic bad,
                                       input logic si, input int idx);
        logic [6:0] w;
        if (idx >= 8) return 1'b1;
        if (idx == 0) return si;
        if (fas) begin
            w = 7'b0011011;
            if (bad) w[0] = ~w[0];
            return w[7 - idx];
        end
        if (idx == 1) return ~bad;
        if (idx == 2) return ra;
        return 1'b1;
    endfunction

    task automatic send_frame(input logic fas, input logic ra, input logic bad,
                              input logic si, input int first, input int last);
        for (int i = first; i <= last; i++) send_bit(frame_bit(fas, ra, bad, si, i));
    endtask

    task automatic full(input logic fas, input logic ra, input logic bad);
        send_frame(fas, ra, bad, 1'b1, 0, 255);
    endtask

    initial begin
        #750000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1", "locked", int'(locked), 0);
        check("R1", "lof_alarm", int'(lof_alarm), 0);
        check("R1", "remote_alarm", int'(remote_alarm), 0);
        check_pos("R1", 0, 0, 1);

        // Scenario table: R3 hunt at any phase, R4 bit-2 check, R5 recurrence check
        for (int s = 0; s < 6; s++) begin
            logic [13:0] v;
            v = SCEN[s];
            do_reset();
            for (int k = 0; k < int'(v[13:6]); k++) send_bit(1'b1);
            full(1'b1, 1'b0, 1'b0);
            full(1'b0, v[5], v[4]);
            full(1'b1, 1'b0, v[3]);
            check("R4/R5", "locked after frame 2", int'(locked), int'(v[2]));
            full(1'b0, v[5], 1'b0);
            full(1'b1, 1'b0, 1'b0);
            check("R5", "locked after frame 4", int'(locked), int'(v[1]));
            check("R9", "remote_alarm", int'(remote_alarm), int'(v[0]));
            if (v[1]) check_pos("R3", 31, 7, 1);
        end

        // Directed: lock, then R7 error runs
        do_reset();
        full(1'b1, 1'b0, 1'b0);
        full(1'b0, 1'b1, 1'b0);
        send_frame(1'b1, 1'b0, 1'b0, 1'b1, 0, 7);
        check("R5", "locked at word end", int'(locked), 1);
        check_pos("R5", 0, 7, 1);
        send_frame(1'b1, 1'b0, 1'b0, 1'b1, 8, 255);
        full(1'b0, 1'b1, 1'b0);
        check("R9", "remote_alarm latched", int'(remote_alarm), 1);
        full(1'b1, 1'b0, 1'b1);
        full(1'b0, 1'b0, 1'b0);
        full(1'b1, 1'b0, 1'b1);
        full(1'b0, 1'b0, 1'b0);
        check("R7", "locked after two errored words", int'(locked), 1);
        full(1'b1, 1'b0, 1'b0);
        full(1'b0, 1'b0, 1'b0);
        full(1'b1, 1'b0, 1'b1);
        full(1'b0, 1'b0, 1'b0);
        full(1'b1, 1'b0, 1'b1);
        full(1'b0, 1'b0, 1'b0);
        check("R7", "locked after broken run", int'(locked), 1);
        check("R7", "lof before third error", int'(lof_alarm), 0);
        send_frame(1'b1, 1'b0, 1'b1, 1'b1, 0, 6);
        check("R7", "locked before bit 8", int'(locked), 1);
        send_frame(1'b1, 1'b0, 1'b1, 1'b1, 7, 7);
        check("R7", "locked after third error", int'(locked), 0);
        check("R7", "lof after third error", int'(lof_alarm), 1);
        send_frame(1'b1, 1'b0, 1'b1, 1'b1, 8, 255);

        // R8: alarm persists through the verify steps, clears on relock
        full(1'b0, 1'b0, 1'b0);
        full(1'b1, 1'b0, 1'b0);
        full(1'b0, 1'b0, 1'b0);
        check("R8", "lof during verify", int'(lof_alarm), 1);
        check("R8", "not locked during verify", int'(locked), 0);
        full(1'b1, 1'b0, 1'b0);
        check("R8", "lof after relock", int'(lof_alarm), 0);
        check("R8", "locked after relock", int'(locked), 1);

        // R9: captured only at bit 3 of the non-FAS slot 0
        send_frame(1'b0, 1'b1, 1'b0, 1'b1, 0, 1);
        check("R9", "remote_alarm before bit 3", int'(remote_alarm), 0);
        send_frame(1'b0, 1'b1, 1'b0, 1'b1, 2, 2);
        check("R9", "remote_alarm at bit 3", int'(remote_alarm), 1);
        check_pos("R3", 0, 2, 0);
        send_frame(1'b0, 1'b1, 1'b0, 1'b1, 3, 255);
        check_pos("R3", 31, 7, 0);
        full(1'b1, 1'b0, 1'b0);
        full(1'b0, 1'b0, 1'b0);
        check("R9", "remote_alarm cleared", int'(remote_alarm), 0);

        // R6: bit 1 of slot 0 cleared in three FAS frames keeps lock
        for (int f = 0; f < 3; f++) begin
            send_frame(1'b1, 1'b0, 1'b0, 1'b0, 0, 255);
            full(1'b0, 1'b0, 1'b0);
        end
        check("R6", "locked with bit 1 cleared", int'(locked), 1);
        check("R6", "no lof with bit 1 cleared", int'(lof_alarm), 0);

        // R2: enable low, toggling data, outputs frozen
        send_frame(1'b1, 1'b0, 1'b0, 1'b1, 0, 4);
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            bit_in = c[0];
        end
        @(negedge clk);
        check_pos("R2", 0, 4, 1);
        check("R2", "locked held", int'(locked), 1);
        send_frame(1'b1, 1'b0, 1'b0, 1'b1, 5, 7);
        check_pos("R2", 0, 7, 1);
        check("R2", "locked after resume", int'(locked), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule